// File: doc/BRIEF.md
# UART Receive Buffer and Line Status

This block sits between a UART receive shifter and the register file. Each time the shifter finishes a character, it strobes the block with the data byte, the parity check result, the raw parity bit and the sampled stop bit. The block stores the character together with its framing and parity/address flag. It keeps the character either in a single holding register or in a small first-in, first-out buffer, depending on a mode input.

Software reads the head character through a receive-buffer read strobe. A separate line status read reports four conditions, and the error flags always describe the character at the head of the buffer. An overrun flag records characters lost because storage was occupied. In multidrop mode the parity flag carries the received parity bit, which marks address bytes, and no longer signals a parity error.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, all four line status bits are 0.
- R2: The line status output is ordered bit 0 data ready, bit 1 overrun, bit 2 parity/address, bit 3 framing.
- R3: Data ready is 1 in the cycle after a character is stored, and returns to 0 once the last stored character has been read.
- R4: With the FIFO enabled, up to DEPTH characters (default 16) are held and read back in arrival order, and `rbr_data` always shows the head character.
- R5: A character whose stop bit is sampled 0 carries a framing flag, and line status bit 3 shows the flag of the head character only.
- R6: Outside multidrop mode, the stored parity flag is the parity error input, and line status bit 2 shows it for the head character.
- R7: In multidrop mode, the stored parity flag is the raw parity bit: 1 marks an address byte and 0 a data byte, whatever the parity error input is.
- R8: A line status read clears the framing and parity flags of the head character and leaves data ready and overrun unchanged.
- R9: When a line status read and a new character that lands at the head happen in the same cycle, the new character's flags are kept.
- R10: With the FIFO disabled, a character that arrives while the holding register is unread replaces it and sets overrun. A read in the same cycle prevents the overrun.
- R11: With the FIFO enabled, a character that arrives while the FIFO is full is discarded and sets overrun.
- R12: Overrun clears on a receive-buffer read, and a new overrun event in the same cycle takes priority.
- R13: A receive-buffer read while nothing is stored changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 selects the FIFO, 0 the single holding register; held stable while data is stored |
| multidrop | input | 1 | 1 stores the raw parity bit as the address marker |
| char_valid | input | 1 | One-cycle strobe from the shifter: a character is complete |
| char_data | input | DATA_W | Received data bits |
| char_par_err | input | 1 | Parity check failed for this character |
| char_par_bit | input | 1 | Received parity bit value |
| char_stop | input | 1 | Sampled stop bit |
| rbr_rd | input | 1 | Receive buffer read strobe (pops the head) |
| lsr_rd | input | 1 | Line status read strobe |
| rbr_data | output | DATA_W | Data of the head character |
| lsr | output | 4 | Line status: {framing, parity/address, overrun, data ready} |

## Verification
The bench builds the block with DEPTH set to 4 and DATA_W left at 8. A shallow FIFO makes the full condition reachable after four characters, so the discard-on-full overrun, the pointer wrap and the in-order drain of a full buffer are all exercised in a few cycles. The holding-register mode, multidrop encoding and same-cycle read/set collisions do not depend on depth and are covered at the same setting.

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              multidrop,
  input  logic              char_valid,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_par_err,
  input  logic              char_par_bit,
  input  logic              char_stop,
  input  logic              rbr_rd,
  input  logic              lsr_rd,
  output logic [DATA_W-1:0] rbr_data,
  output logic [3:0]        lsr
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DATA_W + 2;

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          ovr_q;

  wire empty     = (count == '0);
  wire full      = (count == CW'(DEPTH));
  wire pop       = rbr_rd && !empty;
  wire par_flag  = multidrop ? char_par_bit : char_par_err;
  wire [EW-1:0] new_ent = {~char_stop, par_flag, char_data};
  wire push_fifo = char_valid && fifo_en && !full;
  wire load_hold = char_valid && !fifo_en;
  wire lost      = char_valid && (fifo_en ? full : (!empty && !pop));
  wire [EW-1:0] head = mem[rd_ptr];

  assign rbr_data = head[DATA_W-1:0];
  assign lsr = {!empty && head[EW-1], !empty && head[EW-2], ovr_q, !empty};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (lsr_rd) mem[rd_ptr][EW-1 -: 2] <= 2'b00;
      if (fifo_en) begin
        if (push_fifo) begin
          mem[wr_ptr] <= new_ent;
          wr_ptr      <= wr_ptr + 1'b1;
        end
        if (pop) rd_ptr <= rd_ptr + 1'b1;
        count <= count + CW'(push_fifo) - CW'(pop);
      end else begin
        if (load_hold) mem[rd_ptr] <= new_ent;
        if (load_hold)  count <= CW'(1);
        else if (pop)   count <= '0;
      end
      if (lost)        ovr_q <= 1'b1;
      else if (rbr_rd) ovr_q <= 1'b0;
    end
  end
endmodule

module uart_rx_status_chk #(
  parameter int DEPTH = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         char_valid,
  input logic                         char_stop,
  input logic                         rbr_rd,
  input logic                         lsr_rd,
  input logic                         fifo_en,
  input logic [3:0]                   lsr,
  input logic [$clog2(DEPTH+1)-1:0]   count,
  input logic                         full
);
  a_r3_ready_on_store: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid && !(fifo_en && full) |=> lsr[0]);

  a_r11_full_discard: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && full && char_valid && !rbr_rd |=> lsr[1] && (count == $past(count)));

  a_r10_hold_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en && lsr[0] && char_valid && !rbr_rd |=> lsr[1]);

  a_r8_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd && !char_valid && !rbr_rd |=> (lsr[3:2] == 2'b00) && $stable(lsr[1:0]));

  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid && !char_stop && lsr_rd && !lsr[0] |=> lsr[3]);

  a_r12_overrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rbr_rd && !char_valid |=> !lsr[1]);

  a_r13_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    !lsr[0] && rbr_rd && !char_valid |=> !lsr[0]);
endmodule

bind uart_rx_status uart_rx_status_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_stop(char_stop),
  .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .fifo_en(fifo_en), .lsr(lsr),
  .count(count), .full(full)
);

// File: tb/test_uart_rx_status.sv
module test_uart_rx_status;
  localparam int DW = 8;
  localparam int DP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0, multidrop = 1'b0;
  logic char_valid = 1'b0, char_par_err = 1'b0, char_par_bit = 1'b0, char_stop = 1'b1;
  logic [DW-1:0] char_data = '0;
  logic rbr_rd = 1'b0, lsr_rd = 1'b0;
  logic [DW-1:0] rbr_data;
  logic [3:0] lsr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_rx_status #(.DATA_W(DW), .DEPTH(DP)) i_uart_rx_status (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .multidrop(multidrop),
    .char_valid(char_valid), .char_data(char_data), .char_par_err(char_par_err),
    .char_par_bit(char_par_bit), .char_stop(char_stop), .rbr_rd(rbr_rd),
    .lsr_rd(lsr_rd), .rbr_data(rbr_data), .lsr(lsr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic fen, input logic md);
    @(negedge clk);
    rst_n = 1'b0; fifo_en = fen; multidrop = md;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_char(input logic [DW-1:0] d, input logic perr, input logic pbit, input logic stp);
    char_valid = 1'b1; char_data = d; char_par_err = perr; char_par_bit = pbit; char_stop = stp;
  endtask

  task automatic push(input logic [DW-1:0] d, input logic perr, input logic pbit, input logic stp);
    @(negedge clk);
    set_char(d, perr, pbit, stp);
    @(negedge clk);
    char_valid = 1'b0;
  endtask

  task automatic rd_buf();
    @(negedge clk); rbr_rd = 1'b1;
    @(negedge clk); rbr_rd = 1'b0;
  endtask

  task automatic rd_lsr();
    @(negedge clk); lsr_rd = 1'b1;
    @(negedge clk); lsr_rd = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b0);
    chk("R1 reset status", lsr, 4'b0000);
  endtask

  task automatic t_single();
    do_reset(1'b0, 1'b0);
    push(8'hA5, 1'b0, 1'b0, 1'b1);
    chk("R2 R3 ready only", lsr, 4'b0001);
    chk("R4 head data", rbr_data, 8'hA5);
    rd_buf();
    chk("R3 ready clears", lsr, 4'b0000);
  endtask

  task automatic t_fifo_order();
    do_reset(1'b1, 1'b0);
    push(8'h01, 1'b0, 1'b0, 1'b1);
    push(8'h02, 1'b0, 1'b0, 1'b0);
    push(8'h03, 1'b0, 1'b0, 1'b1);
    chk("R5 head flag only", lsr, 4'b0001);
    chk("R4 first out", rbr_data, 8'h01);
    rd_buf();
    chk("R4 second out", rbr_data, 8'h02);
    chk("R5 framing at head", lsr, 4'b1001);
    rd_lsr();
    chk("R8 framing cleared, ready kept", lsr, 4'b0001);
    rd_buf();
    chk("R4 third out", rbr_data, 8'h03);
    rd_buf();
    chk("R3 drained", lsr, 4'b0000);
  endtask

  task automatic t_parity();
    do_reset(1'b0, 1'b0);
    push(8'h10, 1'b1, 1'b0, 1'b1);
    chk("R6 parity error", lsr, 4'b0101);
    rd_buf();
    do_reset(1'b0, 1'b1);
    push(8'h20, 1'b0, 1'b1, 1'b1);
    chk("R7 address byte", lsr, 4'b0101);
    rd_buf();
    push(8'h21, 1'b1, 1'b0, 1'b1);
    chk("R7 data byte", lsr, 4'b0001);
  endtask

  task automatic t_priority();
    do_reset(1'b0, 1'b0);
    @(negedge clk);
    set_char(8'h33, 1'b1, 1'b0, 1'b0);
    lsr_rd = 1'b1;
    @(negedge clk);
    char_valid = 1'b0; lsr_rd = 1'b0;
    chk("R9 set wins over clear", lsr, 4'b1101);
  endtask

  task automatic t_hold_overrun();
    do_reset(1'b0, 1'b0);
    push(8'h11, 1'b0, 1'b0, 1'b1);
    push(8'h22, 1'b0, 1'b0, 1'b1);
    chk("R10 overrun set", lsr, 4'b0011);
    chk("R10 replaced", rbr_data, 8'h22);
    rd_lsr();
    chk("R8 overrun kept by status read", lsr, 4'b0011);
    rd_buf();
    chk("R12 overrun cleared", lsr, 4'b0000);
    push(8'h44, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    set_char(8'h55, 1'b0, 1'b0, 1'b1);
    rbr_rd = 1'b1;
    @(negedge clk);
    char_valid = 1'b0; rbr_rd = 1'b0;
    chk("R10 read in same cycle avoids overrun", lsr, 4'b0001);
    chk("R10 new char held", rbr_data, 8'h55);
  endtask

  task automatic t_fifo_overrun();
    do_reset(1'b1, 1'b0);
    for (int i = 0; i < DP; i++) push(8'h80 + 8'(i), 1'b0, 1'b0, 1'b1);
    chk("R11 full no overrun yet", lsr, 4'b0001);
    push(8'hEE, 1'b0, 1'b0, 1'b0);
    chk("R11 overrun, flag of lost char absent", lsr, 4'b0011);
    for (int i = 0; i < DP; i++) begin
      chk("R11 R4 order kept", rbr_data, 8'h80 + i);
      rd_buf();
      if (i == 0) chk("R12 overrun cleared on read", lsr[1], 1'b0);
    end
    chk("R11 lost char not stored", lsr, 4'b0000);
    push(8'h5A, 1'b0, 1'b0, 1'b1);
    chk("R4 wrap data", rbr_data, 8'h5A);
  endtask

  task automatic t_empty_read();
    do_reset(1'b1, 1'b0);
    rd_buf();
    chk("R13 empty read", lsr, 4'b0000);
    push(8'h77, 1'b0, 1'b0, 1'b1);
    chk("R13 store after empty read", rbr_data, 8'h77);
    chk("R13 single entry", lsr, 4'b0001);
    rd_buf();
    chk("R13 one read empties", lsr, 4'b0000);
  endtask

  initial begin
    t_reset();
    t_single();
    t_fifo_order();
    t_parity();
    t_priority();
    t_hold_overrun();
    t_fifo_overrun();
    t_empty_read();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule